// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable behavioural model of a single-ported synchronous SRAM. Each word is 36 bits wide and split into four 9-bit byte lanes, and the depth is set by a parameter. Every control, address and write-data input is captured on the rising clock edge. Read data then passes through an output register, so read data appears two clocks after the request is registered.

An access starts when one of two address strobes is seen while all three chip selects are active. The processor-side strobe always starts a read, and the controller-side strobe may start a read or a write. After the start, an advance input steps a 2-bit burst counter, which wraps inside the aligned 4-word group. The step order is either linear or interleaved. Writes go to the lanes picked by per-lane enables, or to all lanes when the global write input is set. An asynchronous output enable gates the data output. The first read after a deselected state is masked for one clock.

Top module: `sync_burst_ram`

## Requirements
- R1: While reset is held and after it is released, `rdValid` is 0 and `rdData` is 0 until a read access completes. After reset the device is in the deselected state.
- R2: A selected read whose inputs are sampled at edge k presents the word on `rdData` with `rdValid`=1 after edge k+2, provided `outEn` is 1.
- R3: A write started by `ctrlStb` updates only the lanes whose `byteWr` bit is 1. Lane i is `wrData[9i+8:9i]`, and `byteWr[i]` enables it.
- R4: When `globalWr` is 1, a write updates all four lanes regardless of `byteWr`.
- R5: A cycle with `procStb`=1 is always a read, even when write inputs are set. If both strobes are set together, the processor strobe wins and the cycle is a read.
- R6: If a strobe is sampled while `chipEn` is not 3'b111, no read or write takes place and the device enters the deselected state.
- R7: With `linearMode`=1, each sampled `advance` moves the address low two bits to (start + n) mod 4. The upper address bits stay fixed.
- R8: With `linearMode`=0, the low two bits on step n are start XOR n.
- R9: In an active burst, a cycle with no strobe and no advance repeats the current address. A read in that cycle returns the same word.
- R10: `outEn` acts in the same cycle. While it is 0, `rdValid` is 0 and `rdData` is 0.
- R11: A read that starts the first access after the deselected state produces no valid output. Later reads in that burst are not masked.
- R12: An `advance` sampled while deselected causes no access and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addrIn | input | ADDR_W | Word address for a new access |
| procStb | input | 1 | Processor-side address strobe (read only) |
| ctrlStb | input | 1 | Controller-side address strobe |
| advance | input | 1 | Step the burst counter |
| linearMode | input | 1 | 1 selects linear order, 0 selects interleaved order |
| chipEn | input | 3 | Chip selects; all must be 1 to select the device |
| globalWr | input | 1 | Write all lanes |
| byteWr | input | LANES | Per-lane write enables |
| wrData | input | LANES*LANE_W | Write data |
| outEn | input | 1 | Asynchronous output enable |
| rdData | output | LANES*LANE_W | Read data, 0 when not valid |
| rdValid | output | 1 | Read data valid |

## Verification
Some rules hold on every clock, and assertions check them there. A strobe with a bad chip select never issues an access, and a processor-strobe cycle never writes. Held cycles keep the address. Each unmasked read reaches the output register two edges later, and a masked first read never shows as valid. Other behaviour needs the bench's scenarios, run against a behavioural memory model. These are the lane-merge results of partial and global writes, the exact linear and interleaved visiting orders with wrap, and that an ignored write leaves memory unchanged. Another is that advance while deselected produces nothing.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic rdEn;    // read the array at accAddr this cycle
    logic wrEn;    // write the enabled lanes at accAddr
    logic maskRd;  // read is first after deselect: suppress output
  } sbrCtl_t;
endpackage

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              procStb,
  input  logic              ctrlStb,
  input  logic              advance,
  input  logic              linearMode,
  input  logic [2:0]        chipEn,
  input  logic              globalWr,
  input  logic [LANES-1:0]  byteWr,
  output sbrCtl_t           ctl,
  output logic [ADDR_W-1:0] accAddr,
  output logic [LANES-1:0]  laneEn
);
  localparam int GRP_W = 2;

  // Input registers
  logic [ADDR_W-1:0] addrQ;
  logic              procQ, ctrlQ, advQ, linQ, gwQ;
  logic [2:0]        csQ;
  logic [LANES-1:0]  bwQ;

  // Burst state
  logic              activeQ, deselQ;
  logic [ADDR_W-1:0] baseQ;
  logic [GRP_W-1:0]  cntQ;

  logic              selOk, anyStb, startAcc, goDesel, curActive, wantWr;
  logic [ADDR_W-1:0] curBase;
  logic [GRP_W-1:0]  curCnt, offset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ <= '0; procQ <= 1'b0; ctrlQ <= 1'b0; advQ <= 1'b0;
      linQ  <= 1'b0; gwQ <= 1'b0; csQ <= '0; bwQ <= '0;
    end else begin
      addrQ <= addrIn; procQ <= procStb; ctrlQ <= ctrlStb; advQ <= advance;
      linQ  <= linearMode; gwQ <= globalWr; csQ <= chipEn; bwQ <= byteWr;
    end
  end

  always_comb begin
    selOk     = &csQ;
    anyStb    = procQ | ctrlQ;
    startAcc  = anyStb & selOk;
    goDesel   = anyStb & ~selOk;
    curActive = startAcc | (activeQ & ~goDesel);
    curBase   = startAcc ? addrQ : baseQ;
    if (startAcc)              curCnt = '0;
    else if (advQ && activeQ)  curCnt = cntQ + GRP_W'(1);
    else                       curCnt = cntQ;
    offset  = linQ ? (curBase[GRP_W-1:0] + curCnt) : (curBase[GRP_W-1:0] ^ curCnt);
    accAddr = {curBase[ADDR_W-1:GRP_W], offset};
    wantWr  = (gwQ | (|bwQ)) & ~procQ;
    ctl.wrEn   = curActive & wantWr;
    ctl.rdEn   = curActive & ~wantWr;
    ctl.maskRd = startAcc & deselQ & ~wantWr;
    laneEn  = gwQ ? {LANES{1'b1}} : bwQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeQ <= 1'b0; deselQ <= 1'b1; baseQ <= '0; cntQ <= '0;
    end else begin
      activeQ <= curActive;
      baseQ   <= curBase;
      cntQ    <= curCnt;
      if (goDesel)       deselQ <= 1'b1;
      else if (startAcc) deselQ <= 1'b0;
    end
  end

  p_desel_no_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((procQ | ctrlQ) && csQ != 3'b111) |-> (!ctl.rdEn && !ctl.wrEn));

  p_proc_is_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    procQ |-> !ctl.wrEn);

  p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (activeQ && !procQ && !ctrlQ && !advQ) |-> (accAddr == $past(accAddr)));
endmodule

// File: rtl/sbr_dpath.sv
module sbr_dpath
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  sbrCtl_t                 ctl,
  input  logic [ADDR_W-1:0]       accAddr,
  input  logic [LANES-1:0]        laneEn,
  input  logic                    outEn,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] wrDataQ, arrRd, outData;
  logic              s1Valid, s1Mask, outValid, outMask;

  always_ff @(posedge clk) begin
    if (!rst_n) wrDataQ <= '0;
    else        wrDataQ <= wrData;
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (ctl.wrEn && laneEn[g])
        laneMem[accAddr] <= wrDataQ[g*LANE_W +: LANE_W];
      if (ctl.rdEn)
        arrRd[g*LANE_W +: LANE_W] <= laneMem[accAddr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1Valid <= 1'b0; s1Mask <= 1'b0;
      outValid <= 1'b0; outMask <= 1'b0; outData <= '0;
    end else begin
      s1Valid  <= ctl.rdEn;
      s1Mask   <= ctl.maskRd;
      outValid <= s1Valid;
      outMask  <= s1Mask;
      outData  <= arrRd;
    end
  end

  always_comb begin
    rdValid = outValid & ~outMask & outEn;
    rdData  = rdValid ? outData : '0;
  end

  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rdEn && !ctl.maskRd) |=> ##1 (outValid && !outMask));

  p_first_read_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rdEn && ctl.maskRd) |=> ##1 !rdValid);
endmodule

// File: rtl/sync_burst_ram.sv
module sync_burst_ram
  import sbr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addrIn,
  input  logic                    procStb,
  input  logic                    ctrlStb,
  input  logic                    advance,
  input  logic                    linearMode,
  input  logic [2:0]              chipEn,
  input  logic                    globalWr,
  input  logic [LANES-1:0]        byteWr,
  input  logic [LANES*LANE_W-1:0] wrData,
  input  logic                    outEn,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);
  sbrCtl_t           ctl;
  logic [ADDR_W-1:0] accAddr;
  logic [LANES-1:0]  laneEn;

  sbr_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .procStb(procStb),
    .ctrlStb(ctrlStb), .advance(advance), .linearMode(linearMode),
    .chipEn(chipEn), .globalWr(globalWr), .byteWr(byteWr),
    .ctl(ctl), .accAddr(accAddr), .laneEn(laneEn)
  );

  sbr_dpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dpath_i (
    .clk(clk), .rst_n(rst_n), .wrData(wrData), .ctl(ctl),
    .accAddr(accAddr), .laneEn(laneEn), .outEn(outEn),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/sync_burst_ram_tb_top.sv
module sync_burst_ram_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int WW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          procStb = 1'b0, ctrlStb = 1'b0, advance = 1'b0, linearMode = 1'b1;
  logic [2:0]    chipEn = 3'b111;
  logic          globalWr = 1'b0;
  logic [3:0]    byteWr = '0;
  logic [WW-1:0] wrData = '0;
  logic          outEn = 1'b1;
  logic [WW-1:0] rdData;
  logic          rdValid;

  int checks = 0, errors = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_burst_ram dut_i (
    .clk(clk), .rst_n(rst_n), .addrIn(addrIn), .procStb(procStb),
    .ctrlStb(ctrlStb), .advance(advance), .linearMode(linearMode),
    .chipEn(chipEn), .globalWr(globalWr), .byteWr(byteWr),
    .wrData(wrData), .outEn(outEn), .rdData(rdData), .rdValid(rdValid)
  );

  // Behavioural reference model
  logic [WW-1:0] mm [128];
  logic [AW-1:0] pAddr; logic pProc, pCtrl, pAdv, pLin, pGw; logic [2:0] pCs;
  logic [3:0] pBw; logic [WW-1:0] pData;
  bit mDesel, mActive; int mBase, mCnt;
  bit s1V, s1M, oV, oM; logic [WW-1:0] s1D, oD;

  task automatic modelReset();
    pAddr = '0; pProc = 0; pCtrl = 0; pAdv = 0; pLin = 0; pGw = 0; pCs = '0;
    pBw = '0; pData = '0;
    mDesel = 1; mActive = 0; mBase = 0; mCnt = 0;
    s1V = 0; s1M = 0; oV = 0; oM = 0; s1D = '0; oD = '0;
  endtask

  task automatic modelEdge();
    bit first; int a, lo; bit wr;
    oV = s1V; oM = s1M; oD = s1D;
    s1V = 0; s1M = 0; first = 0;
    if ((pProc || pCtrl) && pCs == 3'b111) begin
      mActive = 1; mBase = pAddr; mCnt = 0; first = mDesel; mDesel = 0;
    end else if (pProc || pCtrl) begin
      mActive = 0; mDesel = 1;
    end else if (mActive && pAdv) begin
      mCnt = (mCnt + 1) % 4;
    end
    if (mActive) begin
      lo = pLin ? ((mBase % 4) + mCnt) % 4 : ((mBase % 4) ^ mCnt);
      a  = (mBase / 4) * 4 + lo;
      wr = !pProc && (pGw || pBw != 0);
      if (wr) begin
        for (int l = 0; l < 4; l++)
          if (pGw || pBw[l]) mm[a][l*9 +: 9] = pData[l*9 +: 9];
      end else begin
        s1V = 1; s1M = first; s1D = mm[a];
      end
    end
    pAddr = addrIn; pProc = procStb; pCtrl = ctrlStb; pAdv = advance;
    pLin = linearMode; pGw = globalWr; pCs = chipEn; pBw = byteWr; pData = wrData;
  endtask

  task automatic compareOut();
    bit ev; logic [WW-1:0] ed;
    ev = oV && !oM && outEn;
    ed = ev ? oD : '0;
    checks++;
    if (rdValid !== ev || rdData !== ed) begin
      errors++;
      $display("FAIL %s: rdValid=%0b rdData=%h expected rdValid=%0b rdData=%h",
               curReq, rdValid, rdData, ev, ed);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    modelEdge();
    compareOut();
  endtask

  task automatic drive(input bit p, input bit c, input bit adv, input int a,
                       input logic [2:0] cs, input bit gw, input logic [3:0] bw,
                       input logic [WW-1:0] d);
    procStb = p; ctrlStb = c; advance = adv; addrIn = AW'(a); chipEn = cs;
    globalWr = gw; byteWr = bw; wrData = d;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 3'b111, 0, 4'h0, '0);
  endtask

  bit done = 0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) mm[i] = '0;
    modelReset();
    // R1: outputs quiet under reset
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rdValid !== 1'b0 || rdData !== '0) begin
      errors++;
      $display("FAIL R1: rdValid=%0b rdData=%h expected 0 0", rdValid, rdData);
    end
    rst_n = 1'b1;
    curReq = "R1"; idle(3);

    // Preload group 8..15 with full-word writes. The first access after reset is a write (R4).
    curReq = "R4";
    for (int i = 8; i < 16; i++)
      drive(0, 1, 0, i, 3'b111, 1, 4'h0, 36'h0_0000_0100 * i + 36'h1_2345_6000 + i);
    idle(1);
    // R4: global write ignores byteWr
    drive(0, 1, 0, 12, 3'b111, 1, 4'h2, 36'hA_BCDE_F012);
    // R3: partial lanes 0 and 2 at address 9
    curReq = "R3";
    drive(0, 1, 0, 9, 3'b111, 0, 4'b0101, 36'hF_FFFF_FFFF);
    idle(1);
    // R2: plain read latency
    curReq = "R2";
    drive(0, 1, 0, 9, 3'b111, 0, 4'h0, '0);
    drive(0, 1, 0, 12, 3'b111, 0, 4'h0, '0);
    idle(3);

    // R6: strobe with a bad chip select; a write must not happen
    curReq = "R6";
    drive(0, 1, 0, 10, 3'b011, 1, 4'hF, 36'h0_DEAD_BEEF);
    idle(2);
    // R12: advance while deselected gives nothing
    curReq = "R12";
    drive(0, 0, 1, 0, 3'b111, 0, 4'h0, '0);
    drive(0, 0, 1, 0, 3'b111, 0, 4'h0, '0);
    idle(2);
    // R11 then R7: masked first read, linear burst from 10 (10,11,8,9)
    curReq = "R11";
    linearMode = 1'b1;
    drive(1, 0, 0, 10, 3'b111, 0, 4'h0, '0);
    curReq = "R7";
    for (int i = 0; i < 3; i++) drive(0, 0, 1, 0, 3'b111, 0, 4'h0, '0);
    drive(0, 0, 1, 0, 3'b111, 0, 4'h0, '0);
    // R9: hold repeats the word
    curReq = "R9";
    idle(3);

    // R8: interleaved burst starting at 13 (13,12,15,14)
    curReq = "R8";
    linearMode = 1'b0;
    drive(0, 1, 0, 13, 3'b111, 0, 4'h0, '0);
    for (int i = 0; i < 4; i++) drive(0, 0, 1, 0, 3'b111, 0, 4'h0, '0);
    idle(2);

    // R10: output enable low hides a read in the same cycle
    curReq = "R10";
    drive(0, 1, 0, 11, 3'b111, 0, 4'h0, '0);
    drive(0, 0, 0, 0, 3'b111, 0, 4'h0, '0);
    outEn = 1'b0;
    tick();
    outEn = 1'b1;
    tick();
    outEn = 1'b0;
    tick();
    outEn = 1'b1;
    idle(2);

    // R5: proc strobe with write inputs reads; both strobes also read
    curReq = "R5";
    drive(1, 0, 0, 14, 3'b111, 1, 4'hF, 36'h5_5555_5555);
    drive(1, 1, 0, 15, 3'b111, 0, 4'hF, 36'h6_6666_6666);
    idle(2);
    drive(0, 1, 0, 14, 3'b111, 0, 4'h0, '0);
    drive(0, 1, 0, 15, 3'b111, 0, 4'h0, '0);
    drive(0, 1, 0, 10, 3'b111, 0, 4'h0, '0);
    idle(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule